// File: doc/BRIEF.md
# Bus Cycle Start Strobe Controller

This block sits at the front of a processor bus interface and decides the clock in which a new external bus cycle may begin. When it starts a cycle it raises a one-clock address strobe. In the same clock it loads the address, cycle-type bits, byte enables and attribute bits onto the bus outputs, and it holds them there until the final ready of that cycle. It also produces the output enable for the strobe and address group, so that the group floats while another master owns the bus.

Work comes in on two channels, each with a valid/accept handshake. The normal channel carries memory, I/O, locked, special and interrupt-acknowledge cycles. The writeback channel carries cache lines that an inquire cycle found modified. The controller spaces cycles apart by the required dead time after ready, after hold and back-off release, and after the hit-modified indication. It admits only inquire writebacks while address-hold is asserted or the core is in a low-power state. A cycle aborted by back-off is kept and started again, with a fresh strobe, once back-off is released.

Top module: `bcs_ctrl`

## Requirements
- R1: The strobe `ads_o` is high for exactly one clock per bus cycle and is never high in two consecutive clocks.
- R2: A final ready (`rdy_i` high while a cycle is open and back-off is low) ends the cycle. The strobe is low in the next clock and may be high in the clock after that.
- R3: After address-hold, back-off or hold-acknowledge is negated in clock c, the strobe may be high in clock c+1.
- R4: An inquire writeback strobe requires `hitm_i` to have been high in each of the two clocks before the strobe. With `hitm_i` first high in clock c, the strobe is earliest in clock c+2.
- R5: While `ahold_i` is high or `pstate_i` is 1 (halt/shutdown/stop-grant), only writebacks may start. Normal requests wait.
- R6: No strobe follows a clock in which back-off, hold-acknowledge, `rst_i` or `init_i` was high, or in which `pstate_i` was 2 or 3 (stop clock).
- R7: `grp_oe_o` goes low in the clock after `boff_i` is first sampled high. It is low in the same clock in which `hlda_i` is high.
- R8: On a normal start, `addr_o` equals the request address with bits 2..0 cleared, and the type, byte-enable and attribute bits are copied. On a writeback start, `addr_o` has bits 4..0 cleared, `cyc_o` = 3'b111 (memory data write), `be_o` is all ones, `lock_o`=0, `cache_o`=1, and `pcd_o`=`pwt_o`=0.
- R9: Address and qualifier outputs do not change from the strobe until the cycle's final ready or abort.
- R10: When a writeback and a normal request are both eligible in one clock, the writeback starts first.
- R11: Back-off during an open cycle aborts it. After release, the same cycle restarts with a new strobe and unchanged outputs, with no new accept, ahead of new requests.
- R12: Reset clears the open cycle, any pending restart and the turnaround state. While reset is high, the strobe and both accepts are low and `grp_oe_o` is low.
- R13: `req_accept_o` and `wb_accept_o` pulse only in the clock of the strobe that starts the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Init request; blocks new starts |
| rdy_i | input | 1 | Final ready of the open cycle |
| ahold_i | input | 1 | Address hold from system logic |
| boff_i | input | 1 | Back-off from system logic |
| hlda_i | input | 1 | Hold acknowledge |
| hitm_i | input | 1 | Inquire hit on a modified line |
| pstate_i | input | 2 | 0 run, 1 halt/shutdown/stop-grant, 2 or 3 stop clock |
| req_valid_i | input | 1 | Normal request pending |
| req_addr_i | input | ADDR_W | Normal request address |
| req_cyc_i | input | CYC_W | Cycle type bits {mem/io, data/code, write/read} |
| req_be_i | input | BE_W | Byte enables |
| req_lock_i | input | 1 | Locked cycle |
| req_cache_i | input | 1 | Cacheable cycle |
| req_pcd_i | input | 1 | Page cache disable |
| req_pwt_i | input | 1 | Page write-through |
| req_accept_o | output | 1 | Normal request taken |
| wb_valid_i | input | 1 | Inquire writeback pending |
| wb_addr_i | input | ADDR_W | Writeback line address |
| wb_accept_o | output | 1 | Writeback taken |
| ads_o | output | 1 | Address strobe |
| grp_oe_o | output | 1 | Output enable of strobe and address group |
| addr_o | output | ADDR_W | Bus address |
| cyc_o | output | CYC_W | Cycle type bits |
| be_o | output | BE_W | Byte enables |
| lock_o | output | 1 | Lock qualifier |
| cache_o | output | 1 | Cache qualifier |
| pcd_o | output | 1 | Page cache disable qualifier |
| pwt_o | output | 1 | Page write-through qualifier |

## Verification
The bench aims at the dead clock after ready: a controller that forgets it strobes back-to-back, one clock early. It also aims at the two-clock wait after hit-modified, where an early design issues the writeback while the snoop result is still settling. Back-off in mid-cycle is tested by offering a fresh request during the back-off. A design that drops the aborted cycle, or lets the new request overtake it, shows a different address or a spurious accept at the restart strobe. Other directed cases cover address-hold, the low-power and stop-clock states, the float timing of hold-acknowledge, and a reset taken in the middle of an aborted cycle, which must leave no stray restart. Random traffic then checks each strobe against the inputs of the clocks before it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam logic [1:0] PS_RUN    = 2'd0;
  localparam logic [1:0] PS_LOWPWR = 2'd1;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_RESTART = 2'd1,
    SRC_WB      = 2'd2,
    SRC_NORM    = 2'd3
  } src_e;

  // Conditions under which no strobe of any kind may be issued.
  function automatic logic bus_blocked(input logic rst, input logic init,
                                       input logic boff, input logic hlda,
                                       input logic [1:0] ps);
    return rst | init | boff | hlda | ps[1];
  endfunction

  // Conditions under which only inquire writebacks may start.
  function automatic logic wb_only(input logic ahold, input logic [1:0] ps);
    return ahold | (ps == PS_LOWPWR);
  endfunction

  // Fixed priority: aborted cycle, then writeback, then normal request.
  function automatic src_e pick_src(input logic rs_ok, input logic wb_ok,
                                    input logic nm_ok);
    if (rs_ok)      return SRC_RESTART;
    else if (wb_ok) return SRC_WB;
    else if (nm_ok) return SRC_NORM;
    else            return SRC_NONE;
  endfunction

endpackage

// File: rtl/bcs_turnaround.sv
module bcs_turnaround (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hitm_i,
  input  logic rdy_i,
  input  logic boff_i,
  input  logic start_i,
  input  logic start_wb_i,
  input  logic start_restart_i,
  output logic busy_o,
  output logic hitm_aged_o,
  output logic restart_o,
  output logic restart_wb_o,
  output logic cyc_end_o,
  output logic cyc_abort_o
);

  logic busy_q;
  logic hitm_q;
  logic rs_q;
  logic rs_wb_q;
  logic cur_wb_q;

  assign cyc_abort_o  = busy_q & boff_i;
  assign cyc_end_o    = busy_q & rdy_i & ~boff_i;
  assign busy_o       = busy_q;
  assign hitm_aged_o  = hitm_i & hitm_q;
  assign restart_o    = rs_q;
  assign restart_wb_o = rs_wb_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= 1'b0;
      hitm_q   <= 1'b0;
      rs_q     <= 1'b0;
      rs_wb_q  <= 1'b0;
      cur_wb_q <= 1'b0;
    end else begin
      hitm_q <= hitm_i;
      if (start_i) begin
        busy_q   <= 1'b1;
        cur_wb_q <= start_wb_i;
      end else if (cyc_end_o || cyc_abort_o) begin
        busy_q <= 1'b0;
      end
      if (cyc_abort_o) begin
        rs_q    <= 1'b1;
        rs_wb_q <= cur_wb_q;
      end else if (start_i && start_restart_i) begin
        rs_q <= 1'b0;
      end
    end
  end

  // R2: no new cycle may begin while one is open
  assert_no_start_busy_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |-> !start_i);

  // R11: an aborted cycle is always left pending for restart
  assert_abort_keeps_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_abort_o |=> rs_q);

  // R4: the aged hit-modified flag needs two high samples
  assert_hitm_two_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    hitm_aged_o |-> $past(hitm_i));

endmodule

// File: rtl/bcs_select.sv
module bcs_select import bcs_pkg::*; (
  input  logic       rst_i,
  input  logic       init_i,
  input  logic       boff_i,
  input  logic       hlda_i,
  input  logic       ahold_i,
  input  logic [1:0] pstate_i,
  input  logic       busy_i,
  input  logic       restart_i,
  input  logic       restart_wb_i,
  input  logic       hitm_aged_i,
  input  logic       req_valid_i,
  input  logic       wb_valid_i,
  output logic       start_o,
  output src_e       src_o
);

  logic blocked;
  logic restricted;
  logic rs_ok;
  logic wb_ok;
  logic nm_ok;

  always_comb begin
    blocked    = busy_i | bus_blocked(rst_i, init_i, boff_i, hlda_i, pstate_i);
    restricted = wb_only(ahold_i, pstate_i);
    rs_ok      = restart_i & ~blocked & (restart_wb_i | ~restricted);
    wb_ok      = wb_valid_i & hitm_aged_i & ~blocked;
    nm_ok      = req_valid_i & ~blocked & ~restricted & ~restart_i;
    src_o      = pick_src(rs_ok, wb_ok, nm_ok);
    start_o    = (src_o != SRC_NONE);
  end

endmodule

// File: rtl/bcs_hold.sv
module bcs_hold import bcs_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BE_W     = 8,
  parameter int unsigned CYC_W    = 3,
  parameter int unsigned NORM_LSB = 3,
  parameter int unsigned LINE_LSB = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              boff_i,
  input  logic              hlda_i,
  input  logic              start_i,
  input  src_e              src_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CYC_W-1:0]  req_cyc_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              req_lock_i,
  input  logic              req_cache_i,
  input  logic              req_pcd_i,
  input  logic              req_pwt_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  output logic              ads_o,
  output logic              oe_o,
  output logic              req_acc_o,
  output logic              wb_acc_o,
  output logic              line_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [BE_W-1:0]   be_o,
  output logic              lock_o,
  output logic              cache_o,
  output logic              pcd_o,
  output logic              pwt_o
);

  localparam logic [CYC_W-1:0] CYC_LINE_WR = {CYC_W{1'b1}};

  function automatic logic [ADDR_W-1:0] clear_low(input logic [ADDR_W-1:0] a,
                                                  input int unsigned lsb);
    logic [ADDR_W-1:0] mask;
    mask = {ADDR_W{1'b1}} << lsb;
    return a & mask;
  endfunction

  logic ads_q, oe_q, racc_q, wacc_q, line_q;
  logic load_norm, load_line;

  assign load_norm = start_i && (src_i == SRC_NORM);
  assign load_line = start_i && (src_i == SRC_WB);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ads_q   <= 1'b0;
      oe_q    <= 1'b0;
      racc_q  <= 1'b0;
      wacc_q  <= 1'b0;
      line_q  <= 1'b0;
      addr_o  <= '0;
      cyc_o   <= '0;
      be_o    <= '0;
      lock_o  <= 1'b0;
      cache_o <= 1'b0;
      pcd_o   <= 1'b0;
      pwt_o   <= 1'b0;
    end else begin
      ads_q  <= start_i;
      oe_q   <= ~boff_i;
      racc_q <= load_norm;
      wacc_q <= load_line;
      if (load_norm) begin
        line_q  <= 1'b0;
        addr_o  <= clear_low(req_addr_i, NORM_LSB);
        cyc_o   <= req_cyc_i;
        be_o    <= req_be_i;
        lock_o  <= req_lock_i;
        cache_o <= req_cache_i;
        pcd_o   <= req_pcd_i;
        pwt_o   <= req_pwt_i;
      end else if (load_line) begin
        line_q  <= 1'b1;
        addr_o  <= clear_low(wb_addr_i, LINE_LSB);
        cyc_o   <= CYC_LINE_WR;
        be_o    <= {BE_W{1'b1}};
        lock_o  <= 1'b0;
        cache_o <= 1'b1;
        pcd_o   <= 1'b0;
        pwt_o   <= 1'b0;
      end
    end
  end

  assign ads_o     = ads_q;
  assign oe_o      = oe_q & ~hlda_i;
  assign req_acc_o = racc_q;
  assign wb_acc_o  = wacc_q;
  assign line_o    = line_q;

  // R1: one-clock strobe
  assert_single_strobe_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    ads_q |=> !ads_q);

  // R7: float one clock after back-off
  assert_float_boff_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    boff_i |=> !oe_o);

  // R7: float in the clock of hold acknowledge
  assert_float_hlda_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    hlda_i |-> !oe_o);

  // R13: accepts only with a strobe
  assert_accept_strobe_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    (racc_q || wacc_q) |-> ads_q);

  // R8: writeback start carries a line-aligned full-width write
  assert_line_fields_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    wacc_q |-> (addr_o[LINE_LSB-1:0] == '0) && (be_o == {BE_W{1'b1}}) && (cyc_o == CYC_LINE_WR));

  // R8: normal start has the low address bits cleared
  assert_norm_align_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    racc_q |-> (addr_o[NORM_LSB-1:0] == '0));

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl import bcs_pkg::*; #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BE_W     = 8,
  parameter int unsigned CYC_W    = 3,
  parameter int unsigned NORM_LSB = 3,
  parameter int unsigned LINE_LSB = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              init_i,
  input  logic              rdy_i,
  input  logic              ahold_i,
  input  logic              boff_i,
  input  logic              hlda_i,
  input  logic              hitm_i,
  input  logic [1:0]        pstate_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CYC_W-1:0]  req_cyc_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              req_lock_i,
  input  logic              req_cache_i,
  input  logic              req_pcd_i,
  input  logic              req_pwt_i,
  output logic              req_accept_o,
  input  logic              wb_valid_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  output logic              wb_accept_o,
  output logic              ads_o,
  output logic              grp_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [BE_W-1:0]   be_o,
  output logic              lock_o,
  output logic              cache_o,
  output logic              pcd_o,
  output logic              pwt_o
);

  // Named internal events
  logic busy;
  logic hitm_aged;
  logic restart_pend;
  logic restart_wb;
  logic cyc_end;
  logic cyc_abort;
  logic start;
  src_e src;
  logic start_wb_kind;
  logic start_is_restart;
  logic line_cyc;

  assign start_is_restart = (src == SRC_RESTART);
  assign start_wb_kind    = (src == SRC_WB) || (start_is_restart && restart_wb);

  bcs_turnaround u_turn (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .hitm_i          (hitm_i),
    .rdy_i           (rdy_i),
    .boff_i          (boff_i),
    .start_i         (start),
    .start_wb_i      (start_wb_kind),
    .start_restart_i (start_is_restart),
    .busy_o          (busy),
    .hitm_aged_o     (hitm_aged),
    .restart_o       (restart_pend),
    .restart_wb_o    (restart_wb),
    .cyc_end_o       (cyc_end),
    .cyc_abort_o     (cyc_abort)
  );

  bcs_select u_sel (
    .rst_i        (rst_i),
    .init_i       (init_i),
    .boff_i       (boff_i),
    .hlda_i       (hlda_i),
    .ahold_i      (ahold_i),
    .pstate_i     (pstate_i),
    .busy_i       (busy),
    .restart_i    (restart_pend),
    .restart_wb_i (restart_wb),
    .hitm_aged_i  (hitm_aged),
    .req_valid_i  (req_valid_i),
    .wb_valid_i   (wb_valid_i),
    .start_o      (start),
    .src_o        (src)
  );

  bcs_hold #(
    .ADDR_W   (ADDR_W),
    .BE_W     (BE_W),
    .CYC_W    (CYC_W),
    .NORM_LSB (NORM_LSB),
    .LINE_LSB (LINE_LSB)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .boff_i      (boff_i),
    .hlda_i      (hlda_i),
    .start_i     (start),
    .src_i       (src),
    .req_addr_i  (req_addr_i),
    .req_cyc_i   (req_cyc_i),
    .req_be_i    (req_be_i),
    .req_lock_i  (req_lock_i),
    .req_cache_i (req_cache_i),
    .req_pcd_i   (req_pcd_i),
    .req_pwt_i   (req_pwt_i),
    .wb_addr_i   (wb_addr_i),
    .ads_o       (ads_o),
    .oe_o        (grp_oe_o),
    .req_acc_o   (req_accept_o),
    .wb_acc_o    (wb_accept_o),
    .line_o      (line_cyc),
    .addr_o      (addr_o),
    .cyc_o       (cyc_o),
    .be_o        (be_o),
    .lock_o      (lock_o),
    .cache_o     (cache_o),
    .pcd_o       (pcd_o),
    .pwt_o       (pwt_o)
  );

  // R2: dead clock after the final ready
  assert_dead_clock_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_end |=> !ads_o);

  // R6: no strobe after a blocking clock
  assert_blocked_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ads_o |-> $past(!boff_i && !hlda_i && !init_i && !pstate_i[1]));

  // R5: normal cycles only outside address-hold and low-power states
  assert_wb_only_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ads_o && !line_cyc) |-> $past(!ahold_i && (pstate_i == PS_RUN)));

  // R4: writeback strobe at least two clocks after hit-modified
  assert_hitm_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_accept_o |-> ($past(hitm_i, 1) && $past(hitm_i, 2)));

  // R9: bus outputs hold while the cycle is open
  assert_hold_fields_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && !cyc_end && !cyc_abort) |=> ($stable(addr_o) && $stable(be_o) && $stable(cyc_o)));

  // R10: writeback wins over a normal request
  assert_wb_first_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (src == SRC_NORM) |-> !(wb_valid_i && hitm_aged));

  // R11: restarts carry no new accept
  assert_restart_noacc_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    start_is_restart |=> (ads_o && !req_accept_o && !wb_accept_o));

endmodule

// File: tb/bcs_ctrl_tb.sv
module bcs_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst, init, rdy, ahold, boff, hlda, hitm;
  logic [1:0]  pstate;
  logic        req_valid, req_lock, req_cache, req_pcd, req_pwt;
  logic [31:0] req_addr, wb_addr;
  logic [2:0]  req_cyc;
  logic [7:0]  req_be;
  logic        wb_valid;
  logic        req_acc, wb_acc, ads, oe, lock, cache, pcd, pwt;
  logic [31:0] addr;
  logic [2:0]  cyc;
  logic [7:0]  be;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcs_ctrl u_dut (
    .clk_i(clk), .rst_i(rst), .init_i(init), .rdy_i(rdy), .ahold_i(ahold),
    .boff_i(boff), .hlda_i(hlda), .hitm_i(hitm), .pstate_i(pstate),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_cyc_i(req_cyc),
    .req_be_i(req_be), .req_lock_i(req_lock), .req_cache_i(req_cache),
    .req_pcd_i(req_pcd), .req_pwt_i(req_pwt), .req_accept_o(req_acc),
    .wb_valid_i(wb_valid), .wb_addr_i(wb_addr), .wb_accept_o(wb_acc),
    .ads_o(ads), .grp_oe_o(oe), .addr_o(addr), .cyc_o(cyc), .be_o(be),
    .lock_o(lock), .cache_o(cache), .pcd_o(pcd), .pwt_o(pwt)
  );

  function automatic logic [31:0] exp_norm(input logic [31:0] a);
    return {a[31:3], 3'b000};
  endfunction

  function automatic logic [31:0] exp_line(input logic [31:0] a);
    return {a[31:5], 5'b00000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic end_cycle();
    rdy = 1'b1; tick(); rdy = 1'b0; tick();
  endtask

  task automatic put_req(input logic [31:0] a, input logic [2:0] c, input logic [7:0] b);
    req_valid = 1'b1; req_addr = a; req_cyc = c; req_be = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  // random-phase monitor state
  logic p_rst, p_init, p_boff, p_hlda, p_ahold, p_hitm, pp_hitm, p_rdy, p_ads;
  logic [1:0] p_ps;
  logic m_busy;
  logic [31:0] m_last;

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; init = 0; rdy = 0; ahold = 0; boff = 0; hlda = 0; hitm = 0; pstate = 2'd0;
    req_valid = 0; req_addr = 0; req_cyc = 0; req_be = 0;
    req_lock = 0; req_cache = 0; req_pcd = 0; req_pwt = 0;
    wb_valid = 0; wb_addr = 0;
    repeat (3) tick();
    chk("R12 strobe low in reset", ads, 0);
    chk("R12 group floated in reset", oe, 0);
    chk("R12 accepts low in reset", {req_acc, wb_acc}, 0);
    rst = 0;
    tick();
    chk("R12 group enabled after reset", oe, 1);

    // Normal start, fields and stability
    put_req(32'h1234_567F, 3'b010, 8'h0F); req_lock = 1; req_pcd = 1;
    tick();
    chk("R1 strobe on start", ads, 1);
    chk("R13 accept with strobe", req_acc, 1);
    chk("R8 normal address", addr, exp_norm(32'h1234_567F));
    chk("R8 normal qualifiers", {cyc, be, lock, cache, pcd, pwt}, {3'b010, 8'h0F, 4'b1010});
    req_valid = 0; req_addr = 32'hFFFF_FFFF; req_lock = 0; req_pcd = 0;
    tick();
    chk("R1 strobe one clock", ads, 0);
    chk("R13 accept one clock", req_acc, 0);
    tick(); tick();
    chk("R9 address held", addr, 32'h1234_5678);
    chk("R9 lock held", lock, 1);

    // Dead clock after ready
    rdy = 1; put_req(32'hCAFE_0010, 3'b110, 8'hF0);
    tick();
    chk("R2 dead clock after ready", ads, 0);
    rdy = 0;
    tick();
    chk("R2 strobe two clocks after ready", ads, 1);
    chk("R2 new address", addr, 32'hCAFE_0010);
    req_valid = 0;
    tick();

    // Back-off abort and restart
    boff = 1;
    chk("R7 group still driven in back-off clock", oe, 1);
    tick();
    chk("R7 floated one clock after back-off", oe, 0);
    put_req(32'h0BAD_0008, 3'b100, 8'h01);
    tick();
    chk("R6 no strobe during back-off", ads, 0);
    tick();
    chk("R6 no accept during back-off", req_acc, 0);
    boff = 0;
    tick();
    chk("R11 restart strobe after release", ads, 1);
    chk("R11 restart address unchanged", addr, 32'hCAFE_0010);
    chk("R11 no new accept on restart", req_acc, 0);
    chk("R7 group driven again", oe, 1);
    rdy = 1; tick(); rdy = 0; tick();
    chk("R11 queued request after restart", {ads, req_acc}, 2'b11);
    chk("R11 queued address", addr, 32'h0BAD_0008);
    req_valid = 0;
    end_cycle();

    // Address hold
    ahold = 1; put_req(32'h0000_1000, 3'b101, 8'hFF);
    tick(); tick();
    chk("R5 normal held off by address hold", ads, 0);
    ahold = 0;
    tick();
    chk("R3 strobe one clock after hold release", ads, 1);
    req_valid = 0;
    end_cycle();

    // Writeback under address hold, hit-modified spacing
    ahold = 1; put_req(32'h0000_2000, 3'b101, 8'hFF);
    wb_valid = 1; wb_addr = 32'h8765_433F; hitm = 1;
    tick();
    chk("R4 no writeback one clock after hit-modified", ads, 0);
    tick();
    chk("R4 writeback two clocks after hit-modified", {ads, wb_acc, req_acc}, 3'b110);
    chk("R8 writeback address", addr, exp_line(32'h8765_433F));
    chk("R8 writeback qualifiers", {cyc, be, lock, cache, pcd, pwt}, {3'b111, 8'hFF, 4'b0100});
    wb_valid = 0; rdy = 1;
    tick();
    rdy = 0; ahold = 0;
    tick();
    chk("R5 normal after hold drops", {ads, req_acc}, 2'b11);
    chk("R5 normal address", addr, 32'h0000_2000);
    req_valid = 0;
    end_cycle();

    // Priority
    put_req(32'h0000_3000, 3'b101, 8'h3C); wb_valid = 1; wb_addr = 32'h0000_4440;
    tick();
    chk("R10 writeback first", {wb_acc, req_acc}, 2'b10);
    chk("R10 writeback address", addr, 32'h0000_4440);
    wb_valid = 0; rdy = 1; tick(); rdy = 0; tick();
    chk("R10 normal follows", {ads, req_acc}, 2'b11);
    req_valid = 0; hitm = 0;
    end_cycle();

    // Power states and init
    pstate = 2'd2; put_req(32'h0000_5000, 3'b101, 8'hFF);
    tick(); tick();
    chk("R6 no strobe in stop clock", ads, 0);
    pstate = 2'd1;
    tick(); tick();
    chk("R5 no normal in low power", ads, 0);
    init = 1; pstate = 2'd0;
    tick(); tick();
    chk("R6 no strobe during init", ads, 0);
    init = 0;
    tick();
    chk("R6 strobe after init", ads, 1);
    req_valid = 0;
    end_cycle();

    // Hold acknowledge floats at once
    hlda = 1; put_req(32'h0000_6000, 3'b101, 8'hFF);
    #1;
    chk("R7 floated with hold acknowledge", oe, 0);
    tick(); tick();
    chk("R6 no strobe during hold acknowledge", ads, 0);
    hlda = 0;
    tick();
    chk("R3 strobe one clock after hold acknowledge", ads, 1);
    req_valid = 0;
    tick();

    // Reset during an aborted cycle clears the restart
    boff = 1; tick();
    rst = 1; boff = 0; tick();
    chk("R12 strobe low in mid-cycle reset", ads, 0);
    chk("R12 group floated in mid-cycle reset", oe, 0);
    rst = 0;
    tick(); tick(); tick();
    chk("R12 no restart after reset", ads, 0);

    // Random phase
    p_rst = 0; p_init = 0; p_boff = 0; p_hlda = 0; p_ahold = 0; p_hitm = 0;
    pp_hitm = 0; p_rdy = 0; p_ads = 0; p_ps = 0; m_busy = 0; m_last = 0;
    for (int k = 0; k < 4000; k++) begin
      tick();
      if (ads && p_ads) chk("R1 random back-to-back strobe", 1, 0);
      if (ads) chk("R6 random blocked strobe",
                   {p_rst, p_init, p_boff, p_hlda, p_ps[1]}, 0);
      if (ads && !wb_acc && !req_acc && m_busy === 1'b0 && addr != m_last)
        chk("R11 random restart address", addr, m_last);
      if (req_acc) begin
        chk("R5 random normal start", {p_ahold, p_ps}, 0);
        chk("R8 random normal address", addr, exp_norm(req_addr));
      end
      if (wb_acc) begin
        chk("R4 random hit-modified age", {p_hitm, pp_hitm}, 2'b11);
        chk("R8 random line address", addr, exp_line(wb_addr));
      end
      if ((req_acc || wb_acc) && !ads) chk("R13 random accept without strobe", 1, 0);
      // bench cycle tracking
      if (p_rst) m_busy = 0;
      else if (ads) m_busy = 1;
      else if (m_busy && (p_rdy || p_boff)) m_busy = 0;
      if (ads && (req_acc || wb_acc)) m_last = addr;
      if (p_rst) m_last = 32'h0;
      p_ads = ads;
      if (req_acc) req_valid = 0;
      if (wb_acc) wb_valid = 0;
      // new stimulus
      rst  = ($urandom % 300 == 0);
      init = ($urandom % 80 == 0);
      boff = boff ? ($urandom % 3 != 0) : ($urandom % 30 == 0);
      hlda = hlda ? ($urandom % 3 != 0) : ($urandom % 50 == 0);
      ahold = ahold ? ($urandom % 4 != 0) : ($urandom % 20 == 0);
      if ($urandom % 40 == 0) pstate = 2'($urandom % 3);
      if ($urandom % 8 == 0) hitm = ~hitm;
      rdy = m_busy && ($urandom % 3 == 0);
      if (!req_valid && ($urandom % 4 == 0)) begin
        req_valid = 1; req_addr = $urandom; req_cyc = 3'($urandom);
        req_be = 8'($urandom); req_lock = 1'($urandom); req_cache = 1'($urandom);
      end
      if (!wb_valid && ($urandom % 8 == 0)) begin
        wb_valid = 1; wb_addr = $urandom;
      end
      pp_hitm = p_hitm; p_hitm = hitm; p_rst = rst; p_init = init; p_boff = boff;
      p_hlda = hlda; p_ahold = ahold; p_ps = pstate; p_rdy = rdy;
    end
    done = 1'b1;
    finish_run();
  end

endmodule